// File: doc/BRIEF.md
# Flash Command Sequence Front End

This block is the command front end of a byte-wide parallel NOR flash bank. It watches a bus made of a bank enable, an output enable, a write strobe, an address and a data byte. It decodes the multi-write unlock sequences that guard every change to the array. After a complete sequence it starts a byte program, a sector erase or a whole-bank erase, or it switches the read path into an identification mode and back out again.

While an operation runs, the block drives the array through a simple memory port that has a combinational read and a clocked write. For a program it writes one byte. For an erase it walks the address range. Reads of the bank during this time return a status byte instead of array data, and software polls that byte to find out when the operation has finished. A programmable cycle count sets the minimum busy time.

A write is the rising edge of the write strobe, seen on a clock edge, while the bank enable is low and the output enable is high. A read completes on the rising edge of the output enable while the bank enable is low.

Top module: `flashCmdFront`

## Requirements
- R1: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then one write at any address A with data D, start a program. The program stores (old byte at A) AND D, so it can only clear bits.
- R2: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55 then set up an erase. A final write of 0x30 at any address erases the 2^SECTOR_W-byte sector containing that address. A final write of 0x10 at 0x5555 erases the whole bank. Every erased byte becomes 0xFF, and bytes outside the erased range keep their value.
- R3: A write that does not match the next expected step of a sequence abandons that sequence without changing the array. Such a write also leaves identification mode.
- R4: While an operation is busy, bit 6 of the read data is 0 on the first read after the operation starts and changes value on each later read. Once the operation is done, reads return array data, so the toggling stops.
- R5: The status byte is valid from the first read after the final write of a sequence. Bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during an erase. Bits 5 to 0 read 0.
- R6: While an operation is busy, all writes are ignored, including the identification entry sequence and any new program or erase sequence.
- R7: A strobe edge with the output enable low, or with the bank enable high, is not a write. It neither advances nor abandons a sequence.
- R8: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 enter identification mode. In that mode a read of address 0 returns 0xBF, and a read of address 1 returns 0x18 (DEV_VARIANT=0) or 0x19 (DEV_VARIANT=1). Any other address reads 0x00.
- R9: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xF0 leave identification mode, and reads then return array data.
- R10: After reset, and whenever no operation is busy and identification mode is off, a read of address A returns the array byte at A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Bank enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low; the rising edge writes |
| addr | input | ADDR_W | Bus address |
| dataIn | input | 8 | Bus write data |
| dataOut | output | 8 | Bus read data: array byte, identification code or status |
| memAddr | output | ADDR_W | Array port address |
| memWrData | output | 8 | Array port write data |
| memWe | output | 1 | Array port write enable |
| memRdData | input | 8 | Array port read data, combinational for memAddr |

## Verification
Bus command writes can arrive in the same cycle as the internal array writes of an erase walk. The bench provokes this by issuing an identification entry sequence and a full program sequence while a sector erase is still walking. It judges the outcome after completion: address 0 must read array data rather than the identification code, and the program target must be unchanged. Read completions during the walk also fall in the same cycles as the array writes. Here the bench checks that the status byte alternates correctly in bit 6 and that the erased sector still reads back as all 0xFF.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  localparam logic [14:0] SEQ_ADDR_A = 15'h5555;
  localparam logic [14:0] SEQ_ADDR_B = 15'h2AAA;

  typedef struct packed {
    logic loadProg;
    logic loadSector;
    logic loadBank;
    logic idEnter;
    logic idExit;
  } seqStrobes_t;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_CMD, S_PROG, S_ERA1, S_ERA2, S_ERA3, S_BUSY
  } seqState_t;
endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int PROG_TIME  = 16,
  parameter int ERASE_TIME = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic [14:0] keyAddr,
  input  logic [7:0]  dataIn,
  input  logic        walkDone,
  output seqStrobes_t strb,
  output logic        busy
);
  localparam int MAX_TIME = (PROG_TIME > ERASE_TIME) ? PROG_TIME : ERASE_TIME;
  localparam int TMR_W    = $clog2(MAX_TIME + 1);

  seqState_t state, nextState;
  logic weNd;
  logic [TMR_W-1:0] timer;
  logic wrEvent, isA, isB;

  assign wrEvent = weN && !weNd && !ceN && oeN;
  assign isA  = (keyAddr == SEQ_ADDR_A);
  assign isB  = (keyAddr == SEQ_ADDR_B);
  assign busy = (state == S_BUSY);

  always_comb begin
    nextState = state;
    strb = '0;
    case (state)
      S_IDLE: if (wrEvent) begin
        if (isA && dataIn == 8'hAA) nextState = S_UNL1;
        else strb.idExit = 1'b1;
      end
      S_UNL1: if (wrEvent) begin
        if (isB && dataIn == 8'h55) nextState = S_CMD;
        else begin nextState = S_IDLE; strb.idExit = 1'b1; end
      end
      S_CMD: if (wrEvent) begin
        nextState = S_IDLE;
        if (isA && dataIn == 8'hA0)      nextState = S_PROG;
        else if (isA && dataIn == 8'h80) nextState = S_ERA1;
        else if (isA && dataIn == 8'h90) strb.idEnter = 1'b1;
        else strb.idExit = 1'b1;
      end
      S_PROG: if (wrEvent) begin
        nextState = S_BUSY;
        strb.loadProg = 1'b1;
      end
      S_ERA1: if (wrEvent) begin
        if (isA && dataIn == 8'hAA) nextState = S_ERA2;
        else begin nextState = S_IDLE; strb.idExit = 1'b1; end
      end
      S_ERA2: if (wrEvent) begin
        if (isB && dataIn == 8'h55) nextState = S_ERA3;
        else begin nextState = S_IDLE; strb.idExit = 1'b1; end
      end
      S_ERA3: if (wrEvent) begin
        if (dataIn == 8'h30) begin
          nextState = S_BUSY; strb.loadSector = 1'b1;
        end else if (isA && dataIn == 8'h10) begin
          nextState = S_BUSY; strb.loadBank = 1'b1;
        end else begin
          nextState = S_IDLE; strb.idExit = 1'b1;
        end
      end
      S_BUSY: if (timer == '0 && walkDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      weNd  <= 1'b1;
      timer <= '0;
    end else begin
      state <= nextState;
      weNd  <= weN;
      if (strb.loadProg)                        timer <= TMR_W'(PROG_TIME - 1);
      else if (strb.loadSector || strb.loadBank) timer <= TMR_W'(ERASE_TIME - 1);
      else if (busy && timer != '0)             timer <= timer - TMR_W'(1);
    end
  end

  assert_prog_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROG && wrEvent) |=> busy);
  assert_abort_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_UNL1 && wrEvent && !(isB && dataIn == 8'h55)) |=> (state == S_IDLE));
  assert_no_cmd_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (strb == '0));
  assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (ceN || !oeN)) |=> $stable(state));
endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int   ADDR_W    = 15,
  parameter int   SECTOR_W  = 12,
  parameter logic [7:0] DEV_CODE = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  seqStrobes_t       strb,
  input  logic              busy,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWe,
  output logic [7:0]        dataOut,
  output logic              walkDone
);
  localparam int HI_W = ADDR_W - SECTOR_W;

  logic idMode, isProg, toggle, oeNd, readEnd, anyLoad;
  logic [7:0] opData;
  logic [ADDR_W-1:0] walkAddr, walkEnd;

  assign readEnd = oeN && !oeNd && !ceN;
  assign anyLoad = strb.loadProg || strb.loadSector || strb.loadBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idMode   <= 1'b0;
      isProg   <= 1'b0;
      toggle   <= 1'b0;
      oeNd     <= 1'b1;
      opData   <= '0;
      walkAddr <= '0;
      walkEnd  <= '0;
      walkDone <= 1'b1;
    end else begin
      oeNd <= oeN;
      if (strb.idEnter)     idMode <= 1'b1;
      else if (strb.idExit) idMode <= 1'b0;
      if (anyLoad) begin
        walkDone <= 1'b0;
        toggle   <= 1'b0;
        isProg   <= strb.loadProg;
        opData   <= dataIn;
        if (strb.loadProg) begin
          walkAddr <= addr;
          walkEnd  <= addr;
        end else if (strb.loadSector) begin
          walkAddr <= {addr[ADDR_W-1 -: HI_W], {SECTOR_W{1'b0}}};
          walkEnd  <= {addr[ADDR_W-1 -: HI_W], {SECTOR_W{1'b1}}};
        end else begin
          walkAddr <= '0;
          walkEnd  <= '1;
        end
      end else begin
        if (busy && readEnd) toggle <= ~toggle;
        if (memWe) begin
          walkAddr <= walkAddr + ADDR_W'(1);
          if (walkAddr == walkEnd) walkDone <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    memWe     = busy && !walkDone;
    memAddr   = memWe ? walkAddr : addr;
    memWrData = isProg ? (memRdData & opData) : 8'hFF;
    if (busy)
      dataOut = {isProg ? ~opData[7] : 1'b0, toggle, 6'b0};
    else if (idMode)
      dataOut = (addr == '0) ? 8'hBF : (addr == ADDR_W'(1)) ? DEV_CODE : 8'h00;
    else
      dataOut = memRdData;
  end

  assert_prog_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && isProg) |-> ((memWrData & ~memRdData) == 8'h00));
  assert_walk_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (walkAddr <= walkEnd));
  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && readEnd && !anyLoad) |=> (toggle != $past(toggle)));
endmodule

// File: rtl/flashCmdFront.sv
module flashCmdFront
  import flashSeqPkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SECTOR_W    = 12,
  parameter int PROG_TIME   = 16,
  parameter int ERASE_TIME  = 64,
  parameter bit DEV_VARIANT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWe,
  input  logic [7:0]        memRdData
);
  localparam logic [7:0] DEV_CODE = DEV_VARIANT ? 8'h19 : 8'h18;

  seqStrobes_t strb;
  logic busy, walkDone;

  flashSeqCtrl #(.PROG_TIME(PROG_TIME), .ERASE_TIME(ERASE_TIME)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .keyAddr(addr[14:0]), .dataIn(dataIn), .walkDone(walkDone),
    .strb(strb), .busy(busy)
  );

  flashSeqData #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .DEV_CODE(DEV_CODE)) uData (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr), .dataIn(dataIn),
    .strb(strb), .busy(busy), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .memWe(memWe), .dataOut(dataOut), .walkDone(walkDone)
  );
endmodule

// File: tb/tb_flashCmdFront.sv
module tb_flashCmdFront;
  localparam int ADDR_W = 15;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, memWrData, memRdData;
  logic [ADDR_W-1:0] memAddr;
  logic memWe;

  logic [7:0] mem [0:DEPTH-1];
  logic [7:0] refMem [0:DEPTH-1];
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flashCmdFront dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .memAddr(memAddr), .memWrData(memWrData),
    .memWe(memWe), .memRdData(memRdData)
  );

  assign memRdData = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWrData;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                          input bit oeLow = 1'b0, input bit ceHigh = 1'b0);
    @(negedge clk);
    ceN = ceHigh; oeN = !oeLow; weN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [7:0] v);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; addr = a;
    #2 v = dataOut;
    @(negedge clk);
    oeN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic unlock(input logic [7:0] cmd);
    busWrite(15'h5555, 8'hAA);
    busWrite(15'h2AAA, 8'h55);
    busWrite(15'h5555, cmd);
  endtask

  task automatic waitDone(input string tag);
    logic [7:0] prev, cur;
    bit ok = 1'b0;
    busRead('0, prev);
    for (int n = 0; n < 14000 && !ok; n++) begin
      busRead('0, cur);
      if (cur[6] == prev[6]) ok = 1'b1;
      prev = cur;
    end
    check8({tag, " toggle stops"}, {7'b0, ok}, 8'h01);
  endtask

  task automatic eraseSector(input logic [ADDR_W-1:0] a);
    unlock(8'h80);
    busWrite(15'h5555, 8'hAA);
    busWrite(15'h2AAA, 8'h55);
    busWrite(a, 8'h30);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [ADDR_W-1:0] a;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i ^ (i >> 8) ^ 8'h5A);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state reads array data
    for (int i = 0; i < 16; i++) begin
      busRead(ADDR_W'(i * 301), v);
      check8("R10 read after reset", v, refMem[i * 301]);
    end

    // R1 sweep with R4/R5 status sequence
    for (int i = 0; i < 24; i++) begin
      a = ADDR_W'((i * 1237 + 7) % DEPTH);
      d = 8'((i * 37 + 5) ^ (i << 4));
      unlock(8'hA0);
      busWrite(a, d);
      busRead(a, v);
      check8("R5 program status first read", v, {~d[7], 1'b0, 6'b0});
      busRead(a, v);
      check8("R4 program toggle second read", v, {~d[7], 1'b1, 6'b0});
      busRead(a, v);
      check8("R4 program toggle third read", v, {~d[7], 1'b0, 6'b0});
      waitDone("R4 program");
      refMem[a] = refMem[a] & d;
      busRead(a, v);
      check8("R1 programmed byte", v, refMem[a]);
    end

    // R8 / R9 identification mode
    unlock(8'h90);
    busRead(15'd0, v); check8("R8 vendor code", v, 8'hBF);
    busRead(15'd1, v); check8("R8 device code", v, 8'h18);
    busRead(15'd2, v); check8("R8 other address", v, 8'h00);
    unlock(8'hF0);
    busRead(15'd0, v); check8("R9 exit addr0", v, refMem[0]);
    busRead(15'd1, v); check8("R9 exit addr1", v, refMem[1]);

    // R3 aborts
    busWrite(15'h5555, 8'hAA);
    busWrite(15'h2AAA, 8'h55);
    busWrite(15'h1234, 8'hA0);
    busWrite(15'h0100, 8'h00);
    busRead(15'h0100, v); check8("R3 program abort", v, refMem[15'h0100]);
    unlock(8'h80);
    busWrite(15'h5555, 8'hAA);
    busWrite(15'h2AAA, 8'h55);
    busWrite(15'h2200, 8'h20);
    busRead(15'h2200, v); check8("R3 erase abort", v, refMem[15'h2200]);
    unlock(8'h90);
    busWrite(15'h0777, 8'h12);
    busRead(15'd0, v); check8("R3 stray write leaves id mode", v, refMem[0]);

    // R7 inhibited strobes neither advance nor abort
    unlock(8'hA0);
    busWrite(15'h0040, 8'h00, 1'b1, 1'b0);
    busWrite(15'h0041, 8'h00, 1'b0, 1'b1);
    busWrite(15'h0042, 8'h0F);
    waitDone("R7 program");
    refMem[15'h0042] = refMem[15'h0042] & 8'h0F;
    busRead(15'h0040, v); check8("R7 oe low inhibits", v, refMem[15'h0040]);
    busRead(15'h0041, v); check8("R7 ce high inhibits", v, refMem[15'h0041]);
    busRead(15'h0042, v); check8("R7 sequence kept", v, refMem[15'h0042]);

    // R2 sector erase with R5 status
    eraseSector(15'h1ABC);
    busRead(15'h1000, v); check8("R5 erase status", v, 8'h00);
    busRead(15'h1000, v); check8("R4 erase toggle", v, 8'h40);
    waitDone("R2 sector");
    for (int i = 0; i < 4096; i++) begin
      refMem[15'h1000 + i] = 8'hFF;
      busRead(ADDR_W'(15'h1000 + i), v);
      if (v !== 8'hFF || i % 512 == 0) check8("R2 sector byte erased", v, 8'hFF);
    end
    for (int i = 0; i < 64; i++) begin
      busRead(ADDR_W'(15'h2000 + i * 3), v);
      check8("R2 neighbour sector kept", v, refMem[15'h2000 + i * 3]);
      busRead(ADDR_W'(15'h0FFF - i), v);
      check8("R2 lower sector kept", v, refMem[15'h0FFF - i]);
    end

    // R6 commands during busy ignored
    eraseSector(15'h3004);
    unlock(8'h90);
    unlock(8'hA0);
    busWrite(15'h0100, 8'h00);
    waitDone("R6 erase");
    for (int i = 0; i < 4096; i++) refMem[15'h3000 + i] = 8'hFF;
    busRead(15'd0, v); check8("R6 id entry ignored", v, refMem[0]);
    busRead(15'h0100, v); check8("R6 program ignored", v, refMem[15'h0100]);
    busRead(15'h3FFF, v); check8("R6 erase completed", v, 8'hFF);

    // R2 bank erase
    unlock(8'h80);
    busWrite(15'h5555, 8'hAA);
    busWrite(15'h2AAA, 8'h55);
    busWrite(15'h5555, 8'h10);
    waitDone("R2 bank");
    for (int i = 0; i < 256; i++) begin
      busRead(ADDR_W'(i * 128 + (i % 128)), v);
      check8("R2 bank byte erased", v, 8'hFF);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule